// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles every control-transfer instruction of a 32-bit RISC core that always executes one delay-slot instruction after a branch or jump. For each instruction it takes the instruction's own PC, the two source register values, the 16-bit branch offset, the 26-bit jump index, the destination register index and a 4-bit class code. From these it decides whether control transfers, where fetch resumes after the delay slot, and whether a return address is written back.

All outputs are registered, so results appear one clock after the inputs are presented. The `next_pc` output is always the address fetched after the delay slot. It is the computed destination when the transfer is taken, and PC+8 when it is not. The return address points past the delay slot. Fetch, the register file and exception delivery are outside the unit. The misalignment flag is only reported, and the consumer acts on it.

Top module: `branch_resolve_unit`

## Requirements
- R1: While `rst_n` is low, every output reads zero on the following clock. Outside reset, each output reflects the inputs sampled at the previous rising edge, so the latency is exactly one cycle.
- R2: Class codes: 0 none, 1 absolute jump, 2 absolute jump with link, 3 register jump, 4 register jump with link, 5 branch if rs equals rt, 6 branch if rs differs from rt, 7 branch if rs<0, 8 branch if rs>=0, 9 branch if rs>0, 10 branch if rs<=0, 11 branch-and-link if rs<0, 12 branch-and-link if rs>=0. All zero comparisons treat rs as a signed two's-complement value.
- R3: A taken conditional branch sets `taken`=1 and `next_pc` = PC + 4 + (sign-extended offset × 4), modulo 2^32.
- R4: A conditional branch whose condition is false sets `taken`=0 and `next_pc` = PC + 8, so the delay slot still runs.
- R5: Classes 1 and 2 set `taken`=1 and `next_pc` = {PC[31:28], index, 2'b00}.
- R6: Classes 3 and 4 set `taken`=1 and `next_pc` = rs.
- R7: `misalign` is 1 exactly when the class is 3 or 4 and rs[1:0] is nonzero. It is 0 for every other class.
- R8: Class 2 sets `link_we`=1, `link_idx`=31 and `link_val`=PC+8.
- R9: Class 4 writes PC+8 to register `rd_idx`. When `rd_idx` is 0, `link_we`, `link_idx` and `link_val` all read 0.
- R10: Classes 11 and 12 set `link_we`=1, `link_idx`=31 and `link_val`=PC+8, whether or not the branch is taken.
- R11: Class 0 and the undefined codes 13 to 15 give `taken`=0, `next_pc`=PC+8, `link_we`=0, `link_idx`=0, `link_val`=0 and `misalign`=0. The same link-port zeros apply to every class that does not link.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_in | input | 32 | Address of the control-transfer instruction |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| br_offset | input | 16 | Signed word offset for conditional branches |
| jump_index | input | 26 | Word index for absolute jumps |
| rd_idx | input | 5 | Destination register of a register jump with link |
| op_class | input | 4 | Instruction class code (see R2) |
| taken | output | 1 | Control transfer happens after the delay slot |
| next_pc | output | 32 | Fetch address following the delay slot |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Register written with the return address |
| link_val | output | 32 | Return address (PC+8) |
| misalign | output | 1 | Register-jump target has nonzero low bits |

## Verification
The bench probes the sign boundary with rs = 80000000h and rs = 0. An unsigned compare there would take rs<0 branches wrongly, and a test that excluded zero would split >= from >. Negative offsets and a PC near the top of the space exercise sign extension and wraparound. A design that used PC instead of PC+4 as the base, or zero-filled the offset, would land one word or many kilobytes off. Not-taken linking branches must still write register 31. A register jump with link to register 0 must write nothing. The upper PC nibble must survive absolute jumps, and misaligned register targets must raise the flag only for register jumps.

// File: rtl/brj_pkg.sv
// Package: class codes and shared constants of the branch resolution unit.
// Assumes a 4-bit class field; codes 13..15 are undefined and act as "none".
package brj_pkg;
    localparam int CLS_W = 4;

    localparam logic [CLS_W-1:0] CLS_NONE        = 4'd0;
    localparam logic [CLS_W-1:0] CLS_JABS        = 4'd1;
    localparam logic [CLS_W-1:0] CLS_JABS_LINK   = 4'd2;
    localparam logic [CLS_W-1:0] CLS_JREG        = 4'd3;
    localparam logic [CLS_W-1:0] CLS_JREG_LINK   = 4'd4;
    localparam logic [CLS_W-1:0] CLS_BR_EQ       = 4'd5;
    localparam logic [CLS_W-1:0] CLS_BR_NE       = 4'd6;
    localparam logic [CLS_W-1:0] CLS_BR_LTZ      = 4'd7;
    localparam logic [CLS_W-1:0] CLS_BR_GEZ      = 4'd8;
    localparam logic [CLS_W-1:0] CLS_BR_GTZ      = 4'd9;
    localparam logic [CLS_W-1:0] CLS_BR_LEZ      = 4'd10;
    localparam logic [CLS_W-1:0] CLS_BR_LTZ_LINK = 4'd11;
    localparam logic [CLS_W-1:0] CLS_BR_GEZ_LINK = 4'd12;

    // Decoded view of one class code, shared by the sub-units.
    typedef struct packed {
        logic is_cond;    // conditional branch
        logic is_jabs;    // absolute jump
        logic is_jreg;    // register jump
        logic link_fix;   // links to the fixed return register
        logic link_rd;    // links to rd
    } cls_dec_t;

    // Turn a class code into its decoded flags.
    function automatic cls_dec_t decode_class(input logic [CLS_W-1:0] c);
        cls_dec_t d;
        d = '0;
        case (c)
            CLS_JABS:        d.is_jabs = 1'b1;
            CLS_JABS_LINK:   begin d.is_jabs = 1'b1; d.link_fix = 1'b1; end
            CLS_JREG:        d.is_jreg = 1'b1;
            CLS_JREG_LINK:   begin d.is_jreg = 1'b1; d.link_rd = 1'b1; end
            CLS_BR_EQ, CLS_BR_NE, CLS_BR_LTZ,
            CLS_BR_GEZ, CLS_BR_GTZ, CLS_BR_LEZ: d.is_cond = 1'b1;
            CLS_BR_LTZ_LINK,
            CLS_BR_GEZ_LINK: begin d.is_cond = 1'b1; d.link_fix = 1'b1; end
            default:         d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/brj_cond_eval.sv
// Module: evaluates the condition of a conditional branch class.
// Assumes operands are two's-complement; output is 0 for non-branch classes.
module brj_cond_eval
    import brj_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [CLS_W-1:0] op_class,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output logic             cond_true
);
    logic rs_neg;
    logic rs_zero;
    logic ops_equal;

    // Primitive comparisons shared by all conditions.
    always_comb begin
        rs_neg    = rs_val[XLEN-1];
        rs_zero   = (rs_val == '0);
        ops_equal = (rs_val == rt_val);
    end

    // Select the condition for the class.
    always_comb begin
        case (op_class)
            CLS_BR_EQ:                    cond_true = ops_equal;
            CLS_BR_NE:                    cond_true = !ops_equal;
            CLS_BR_LTZ, CLS_BR_LTZ_LINK:  cond_true = rs_neg;
            CLS_BR_GEZ, CLS_BR_GEZ_LINK:  cond_true = !rs_neg;
            CLS_BR_GTZ:                   cond_true = !rs_neg && !rs_zero;
            CLS_BR_LEZ:                   cond_true = rs_neg || rs_zero;
            default:                      cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/brj_target_gen.sv
// Module: forms the post-delay-slot fetch address and the misalignment flag.
// Assumes word-aligned instructions; the absolute jump keeps the PC bits above
// the shifted index, branch bases are the delay-slot address PC+4.
module brj_target_gen
    import brj_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int OFFW = 16,
    parameter int IDXW = 26
) (
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] rs_val,
    input  logic [OFFW-1:0] br_offset,
    input  logic [IDXW-1:0] jump_index,
    input  cls_dec_t        dec,
    input  logic            take,
    output logic [XLEN-1:0] next_pc,
    output logic            misalign
);
    localparam int KEEP_HI = XLEN - IDXW - 2;
    localparam int EXT_W   = XLEN - OFFW - 2;

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] slot_pc;
    logic [XLEN-1:0] br_dest;
    logic [XLEN-1:0] abs_dest;

    // Candidate addresses for each kind of transfer.
    always_comb begin
        slot_pc  = pc_in + XLEN'(4);
        seq_pc   = pc_in + XLEN'(8);
        br_dest  = slot_pc + {{EXT_W{br_offset[OFFW-1]}}, br_offset, 2'b00};
        abs_dest = {pc_in[XLEN-1 -: KEEP_HI], jump_index, 2'b00};
    end

    // Pick the resume address and flag unaligned register targets.
    always_comb begin
        next_pc = seq_pc;
        if (take) begin
            if (dec.is_jabs)      next_pc = abs_dest;
            else if (dec.is_jreg) next_pc = rs_val;
            else                  next_pc = br_dest;
        end
        misalign = dec.is_jreg && (rs_val[1:0] != 2'b00);
    end
endmodule

// File: rtl/brj_link_gen.sv
// Module: produces the return-address write request.
// Assumes the fixed return register index is a parameter and that index 0 is
// a hardwired zero register, so a write to it is dropped here.
module brj_link_gen
    import brj_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0] pc_in,
    input  logic [REGW-1:0] rd_idx,
    input  cls_dec_t        dec,
    output logic            link_we,
    output logic [REGW-1:0] link_idx,
    output logic [XLEN-1:0] link_val
);
    logic [REGW-1:0] want_idx;
    logic            want_we;

    // Choose the destination register for the link.
    always_comb begin
        want_idx = '0;
        want_we  = 1'b0;
        if (dec.link_fix) begin
            want_idx = REGW'(LINK_REG);
            want_we  = 1'b1;
        end else if (dec.link_rd) begin
            want_idx = rd_idx;
            want_we  = 1'b1;
        end
    end

    // Suppress writes to register 0 and zero the idle port.
    always_comb begin
        link_we  = want_we && (want_idx != '0);
        link_idx = link_we ? want_idx : '0;
        link_val = link_we ? (pc_in + XLEN'(8)) : '0;
    end
endmodule

// File: rtl/branch_resolve_unit.sv
// Module: top of the branch and jump resolution unit.
// Decodes the class, evaluates the condition, forms the resume address and the
// link request, and registers all results (one cycle latency, sync low reset).
// Assumes one delay slot after every control transfer.
module branch_resolve_unit
    import brj_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFFW     = 16,
    parameter int IDXW     = 26,
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_in,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [OFFW-1:0]  br_offset,
    input  logic [IDXW-1:0]  jump_index,
    input  logic [REGW-1:0]  rd_idx,
    input  logic [CLS_W-1:0] op_class,
    output logic             taken,
    output logic [XLEN-1:0]  next_pc,
    output logic             link_we,
    output logic [REGW-1:0]  link_idx,
    output logic [XLEN-1:0]  link_val,
    output logic             misalign
);
    cls_dec_t        dec;
    logic            cond_true;
    logic            take_c;
    logic [XLEN-1:0] next_pc_c;
    logic            misalign_c;
    logic            link_we_c;
    logic [REGW-1:0] link_idx_c;
    logic [XLEN-1:0] link_val_c;

    // Decode the class and merge unconditional and conditional transfers.
    always_comb begin
        dec    = decode_class(op_class);
        take_c = dec.is_jabs || dec.is_jreg || (dec.is_cond && cond_true);
    end

    brj_cond_eval #(.XLEN(XLEN)) u_cond (
        .op_class  (op_class),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .cond_true (cond_true)
    );

    brj_target_gen #(.XLEN(XLEN), .OFFW(OFFW), .IDXW(IDXW)) u_target (
        .pc_in      (pc_in),
        .rs_val     (rs_val),
        .br_offset  (br_offset),
        .jump_index (jump_index),
        .dec        (dec),
        .take       (take_c),
        .next_pc    (next_pc_c),
        .misalign   (misalign_c)
    );

    brj_link_gen #(.XLEN(XLEN), .REGW(REGW), .LINK_REG(LINK_REG)) u_link (
        .pc_in    (pc_in),
        .rd_idx   (rd_idx),
        .dec      (dec),
        .link_we  (link_we_c),
        .link_idx (link_idx_c),
        .link_val (link_val_c)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            next_pc  <= '0;
            link_we  <= 1'b0;
            link_idx <= '0;
            link_val <= '0;
            misalign <= 1'b0;
        end else begin
            taken    <= take_c;
            next_pc  <= next_pc_c;
            link_we  <= link_we_c;
            link_idx <= link_idx_c;
            link_val <= link_val_c;
            misalign <= misalign_c;
        end
    end
endmodule

// File: rtl/brj_checker.sv
// Module: property checker for branch_resolve_unit, attached by bind.
// Assumes the default 32-bit layout (upper 4 PC bits kept by absolute jumps).
module brj_checker
    import brj_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int REGW = 5,
    parameter int LINK_REG = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  pc_in,
    input logic [CLS_W-1:0] op_class,
    input logic             taken,
    input logic [XLEN-1:0]  next_pc,
    input logic             link_we,
    input logic [REGW-1:0]  link_idx,
    input logic [XLEN-1:0]  link_val,
    input logic             misalign
);
    logic primed;

    // Marks cycles whose previous sample was taken outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R1: reset clears every output on the next edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!taken && next_pc == '0 && !link_we && link_idx == '0
                    && link_val == '0 && !misalign));

    // R4: an untaken conditional branch resumes past the delay slot.
    a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken && $past(op_class) >= CLS_BR_EQ
                && $past(op_class) <= CLS_BR_GEZ_LINK)
        |-> next_pc == $past(pc_in) + XLEN'(8));

    // R5: absolute jumps keep the top PC nibble and are word aligned.
    a_r5_abs_region: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ($past(op_class) == CLS_JABS || $past(op_class) == CLS_JABS_LINK))
        |-> (taken && next_pc[XLEN-1 -: 4] == $past(pc_in[XLEN-1 -: 4])
             && next_pc[1:0] == 2'b00));

    // R7: misalignment only accompanies a taken unaligned transfer.
    a_r7_misalign_jump: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (taken && next_pc[1:0] != 2'b00));

    // R8: jump with link returns past the delay slot into the fixed register.
    a_r8_jal_link: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_class) == CLS_JABS_LINK)
        |-> (link_we && link_idx == REGW'(LINK_REG) && link_val == $past(pc_in) + XLEN'(8)));

    // R9: register 0 is never written.
    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_idx != '0);

    // R10: linking branches write the return register taken or not.
    a_r10_cond_link: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ($past(op_class) == CLS_BR_LTZ_LINK || $past(op_class) == CLS_BR_GEZ_LINK))
        |-> (link_we && link_idx == REGW'(LINK_REG)));

    // R11: idle classes raise nothing.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ($past(op_class) == CLS_NONE || $past(op_class) > CLS_BR_GEZ_LINK))
        |-> (!taken && !link_we && !misalign));
endmodule

bind branch_resolve_unit brj_checker #(.XLEN(XLEN), .REGW(REGW), .LINK_REG(LINK_REG)) u_brj_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_in    (pc_in),
    .op_class (op_class),
    .taken    (taken),
    .next_pc  (next_pc),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val),
    .misalign (misalign)
);

// File: tb/branch_resolve_unit_test.sv
`timescale 1ns/1ps
// Directed bench for branch_resolve_unit: one task per scenario.
module branch_resolve_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_in = '0, rs_val = '0, rt_val = '0;
    logic [15:0] br_offset = '0;
    logic [25:0] jump_index = '0;
    logic [4:0]  rd_idx = '0;
    logic [3:0]  op_class = '0;
    logic        taken, link_we, misalign;
    logic [31:0] next_pc, link_val;
    logic [4:0]  link_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    branch_resolve_unit uut (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .rs_val(rs_val), .rt_val(rt_val),
        .br_offset(br_offset), .jump_index(jump_index), .rd_idx(rd_idx),
        .op_class(op_class), .taken(taken), .next_pc(next_pc), .link_we(link_we),
        .link_idx(link_idx), .link_val(link_val), .misalign(misalign)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Conditional-branch destination from R3.
    function automatic logic [31:0] br_dest(input logic [31:0] pc, input logic [15:0] off);
        return pc + 32'd4 + ({{16{off[15]}}, off} << 2);
    endfunction

    // Apply one instruction, wait one cycle and compare every output.
    task automatic run_case(input string req, input logic [3:0] cls,
                            input logic [31:0] pc, input logic [31:0] rs,
                            input logic [31:0] rt, input logic [15:0] off,
                            input logic [25:0] idx, input logic [4:0] rd,
                            input logic e_tk, input logic [31:0] e_pc,
                            input logic e_we, input logic [4:0] e_idx,
                            input logic [31:0] e_lv, input logic e_mis);
        op_class = cls; pc_in = pc; rs_val = rs; rt_val = rt;
        br_offset = off; jump_index = idx; rd_idx = rd;
        @(negedge clk);
        chk(req, "taken",    {31'd0, taken},    {31'd0, e_tk});
        chk(req, "next_pc",  next_pc,           e_pc);
        chk(req, "link_we",  {31'd0, link_we},  {31'd0, e_we});
        chk(req, "link_idx", {27'd0, link_idx}, {27'd0, e_idx});
        chk(req, "link_val", link_val,          e_lv);
        chk(req, "misalign", {31'd0, misalign}, {31'd0, e_mis});
    endtask

    // R1: outputs zero under reset even with a live jump-and-link presented.
    task automatic t_reset;
        rst_n = 1'b0;
        op_class = 4'd2; pc_in = 32'h1000_0000; jump_index = 26'h3;
        @(negedge clk); @(negedge clk);
        chk("R1", "taken",    {31'd0, taken},   32'd0);
        chk("R1", "next_pc",  next_pc,          32'd0);
        chk("R1", "link_we",  {31'd0, link_we}, 32'd0);
        chk("R1", "link_val", link_val,         32'd0);
        chk("R1", "misalign", {31'd0, misalign}, 32'd0);
        op_class = 4'd0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2 R3 R4: equality and inequality branches.
    task automatic t_eq_ne;
        run_case("R3", 4'd5, 32'h0000_1000, 32'd7, 32'd7, 16'h0010, '0, '0,
                 1, br_dest(32'h0000_1000, 16'h0010), 0, 0, 0, 0);
        run_case("R4", 4'd5, 32'h0000_1000, 32'd7, 32'd8, 16'h0010, '0, '0,
                 0, 32'h0000_1008, 0, 0, 0, 0);
        run_case("R2", 4'd6, 32'h0000_2000, 32'd1, 32'd2, 16'hFFFE, '0, '0,
                 1, 32'h0000_1FFC, 0, 0, 0, 0);
        run_case("R4", 4'd6, 32'h0000_2000, 32'd5, 32'd5, 16'hFFFE, '0, '0,
                 0, 32'h0000_2008, 0, 0, 0, 0);
    endtask

    // R2: signed zero comparisons at the sign and zero boundaries.
    task automatic t_zero_cmp;
        run_case("R2", 4'd7,  32'h100, 32'h8000_0000, 0, 16'h4, '0, '0, 1, 32'h114, 0, 0, 0, 0);
        run_case("R2", 4'd7,  32'h100, 32'h0,         0, 16'h4, '0, '0, 0, 32'h108, 0, 0, 0, 0);
        run_case("R2", 4'd8,  32'h100, 32'h0,         0, 16'h4, '0, '0, 1, 32'h114, 0, 0, 0, 0);
        run_case("R2", 4'd8,  32'h100, 32'hFFFF_FFFF, 0, 16'h4, '0, '0, 0, 32'h108, 0, 0, 0, 0);
        run_case("R2", 4'd9,  32'h100, 32'h0,         0, 16'h4, '0, '0, 0, 32'h108, 0, 0, 0, 0);
        run_case("R2", 4'd9,  32'h100, 32'h7FFF_FFFF, 0, 16'h4, '0, '0, 1, 32'h114, 0, 0, 0, 0);
        run_case("R2", 4'd10, 32'h100, 32'h0,         0, 16'h4, '0, '0, 1, 32'h114, 0, 0, 0, 0);
        run_case("R2", 4'd10, 32'h100, 32'h1,         0, 16'h4, '0, '0, 0, 32'h108, 0, 0, 0, 0);
    endtask

    // R3: most negative offset and wraparound near the top of the space.
    task automatic t_offsets;
        run_case("R3", 4'd5, 32'h0004_0000, 0, 0, 16'h8000, '0, '0,
                 1, br_dest(32'h0004_0000, 16'h8000), 0, 0, 0, 0);
        run_case("R3", 4'd5, 32'hFFFF_FFF8, 0, 0, 16'h0002, '0, '0,
                 1, 32'h0000_0004, 0, 0, 0, 0);
    endtask

    // R5 R8: absolute jumps keep PC[31:28].
    task automatic t_abs;
        run_case("R5", 4'd1, 32'hA123_4560, 0, 0, 0, 26'h3FF_FFFF, '0,
                 1, 32'hAFFF_FFFC, 0, 0, 0, 0);
        run_case("R8", 4'd2, 32'h5000_0100, 0, 0, 0, 26'h000_0040, 5'd9,
                 1, 32'h5000_0100, 1, 5'd31, 32'h5000_0108, 0);
    endtask

    // R6 R7 R9: register jumps, alignment and link destination.
    task automatic t_reg;
        run_case("R6", 4'd3, 32'h400, 32'h8000_0010, 0, 0, '0, '0,
                 1, 32'h8000_0010, 0, 0, 0, 0);
        run_case("R7", 4'd3, 32'h400, 32'h8000_0012, 0, 0, '0, '0,
                 1, 32'h8000_0012, 0, 0, 0, 1);
        run_case("R9", 4'd4, 32'h400, 32'h0000_2001, 0, 0, '0, 5'd5,
                 1, 32'h0000_2001, 1, 5'd5, 32'h408, 1);
        run_case("R9", 4'd4, 32'h400, 32'h0000_3000, 0, 0, '0, 5'd0,
                 1, 32'h0000_3000, 0, 0, 0, 0);
        run_case("R7", 4'd5, 32'h400, 32'h3, 32'h3, 16'h1, '0, '0,
                 1, 32'h408, 0, 0, 0, 0);
    endtask

    // R10: linking branches write r31 whether taken or not.
    task automatic t_cond_link;
        run_case("R10", 4'd11, 32'h600, 32'h1, 0, 16'h8, '0, 5'd3,
                 0, 32'h608, 1, 5'd31, 32'h608, 0);
        run_case("R10", 4'd11, 32'h600, 32'hF000_0000, 0, 16'h8, '0, '0,
                 1, 32'h624, 1, 5'd31, 32'h608, 0);
        run_case("R10", 4'd12, 32'h600, 32'h8000_0000, 0, 16'h8, '0, '0,
                 0, 32'h608, 1, 5'd31, 32'h608, 0);
        run_case("R10", 4'd12, 32'h600, 32'h0, 0, 16'hFFFF, '0, '0,
                 1, 32'h600, 1, 5'd31, 32'h608, 0);
    endtask

    // R11: none and undefined codes are quiet even with misaligned rs.
    task automatic t_idle;
        run_case("R11", 4'd0,  32'h700, 32'h3, 32'h3, 16'h1, 26'h1, 5'd7,
                 0, 32'h708, 0, 0, 0, 0);
        run_case("R11", 4'd13, 32'h700, 32'h3, 32'h3, 16'h1, 26'h1, 5'd7,
                 0, 32'h708, 0, 0, 0, 0);
        run_case("R11", 4'd15, 32'h700, 32'h0, 32'h0, 16'h1, 26'h1, 5'd7,
                 0, 32'h708, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_eq_ne();
        t_zero_cmp();
        t_offsets();
        t_abs();
        t_reg();
        t_cond_link();
        t_idle();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule